// File: doc/BRIEF.md
# Dual-Mode Dual-Clock FIFO

This block is a FIFO whose writer and reader run on clocks that have no fixed relationship. A dual-port memory holds the words. The write and read pointers are one bit wider than the address. They pass between the two clock domains in Gray code through two-flop synchronisers, so each flag is built entirely in the domain that owns it.

A mode input is captured while master reset is held, and it chooses between two protocols.

- **Standard mode.** `wflag_o` is an active-low full flag and `rflag_o` is an active-low empty flag. Each word, the first one included, reaches `rdata_o` only when `ren_i` requests it.
- **Fall-through mode.** `wflag_o` is an active-low input-ready flag and `rflag_o` is an active-low output-ready flag. The oldest word moves into the output register without a request. The output register therefore counts as one more storage slot, and the FIFO holds DEPTH+1 words.

A partial reset clears the contents and the flags but leaves the selected mode unchanged. Either clock may be stopped. Flags driven by a stopped clock hold their value until that clock runs again.

Top module: `dual_mode_fifo`

## Requirements
- R1: In standard mode (mode captured as 0), `wflag_o` is 1 until DEPTH words are stored with no reads and is 0 once the DEPTH-th write completes.
- R2: In fall-through mode (mode captured as 1), `wflag_o` is 0 while space remains and becomes 1 only after DEPTH+1 writes with no reads, the extra word sitting in the output register.
- R3: A write request while the FIFO is full stores nothing; the words read afterwards are exactly those accepted before it.
- R4: A read request while nothing is available changes neither `rdata_o` nor the read pointer; later data is read back in order.
- R5: In standard mode `rdata_o` changes only on a read-clock edge where `ren_i` is 1 and the FIFO is not empty, and then it shows the oldest word; `rflag_o` is 0 exactly when no word is stored.
- R6: In fall-through mode a word written into an empty FIFO appears on `rdata_o`, with `rflag_o` falling to 0, on the third rising read-clock edge after the write edge, with no read request.
- R7: In fall-through mode, once the last word is on `rdata_o`, `rflag_o` stays 0 until a read-clock edge with `ren_i` at 1. It then rises to 1 while `rdata_o` keeps that word.
- R8: A flag released by the other side is released on the second rising edge of its own clock after the other side's operation: `wflag_o` after a read, and the standard-mode `rflag_o` after a write.
- R9: While `rclk_i` is stopped, `rflag_o` does not change even when words are written. After the clock resumes, `rflag_o` updates within two read-clock edges.
- R10: The mode is captured only while `rst_ni` is 0. A pulse on `prst_ni` empties the FIFO and restores the reset flag values, but keeps the mode.
- R11: After any reset, `rdata_o` is 0. Standard mode then shows `wflag_o`=1 and `rflag_o`=0; fall-through mode shows `wflag_o`=0 and `rflag_o`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write clock |
| rclk_i | input | 1 | Read clock |
| rst_ni | input | 1 | Master reset, active low, asynchronous; mode is captured while low (both clocks must run) |
| prst_ni | input | 1 | Partial reset, active low, asynchronous; keeps the mode |
| fwft_i | input | 1 | Mode select: 0 standard, 1 fall-through |
| wen_i | input | 1 | Write enable, active high |
| wdata_i | input | WIDTH | Write data |
| ren_i | input | 1 | Read enable, active high |
| rdata_o | output | WIDTH | Registered read data |
| wflag_o | output | 1 | Standard: full, active low. Fall-through: input-ready, active low |
| rflag_o | output | 1 | Standard: empty, active low. Fall-through: output-ready, active low |

## Verification
Wrong pointer or synchroniser state shows at the ports within a few clock edges. A pointer that skips or stalls returns words out of order, or fills and drains at the wrong count. A broken synchroniser releases a flag on the wrong edge, one edge early or late compared with the two-edge rule. A wrong output-register valid bit in fall-through mode shows either as a word that never falls through by the third read edge, or as output-ready rising without a read. Since the output register holds one word in that mode, a capacity error of exactly one word separates the modes.

// File: rtl/dmf_pkg.sv
package dmf_pkg;
  typedef enum logic {
    MODE_STD  = 1'b0,
    MODE_FWFT = 1'b1
  } fifo_mode_e;
endpackage

// File: rtl/dmf_sync.sv
module dmf_sync #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/dmf_ram.sv
module dmf_ram #(
  parameter int WIDTH = 18,
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             wclk_i,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [AW-1:0]    raddr_i,
  output logic [WIDTH-1:0] rdata_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];

  always_ff @(posedge wclk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  // read side registers this value in its output stage
  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/dmf_wr_ctrl.sv
module dmf_wr_ctrl
  import dmf_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          wclk_i,
  input  logic          mrst_ni,
  input  logic          arst_ni,
  input  logic          mode_sel_i,
  input  logic          wen_i,
  input  logic [AW:0]   rgray_sync_i,
  output logic          we_o,
  output logic [AW-1:0] waddr_o,
  output logic [AW:0]   wgray_o,
  output logic          wflag_o
);
  fifo_mode_e  mode_q;
  logic [AW:0] wbin_q, wgray_q, wbin_nxt;
  logic        full;

  // mode captured on the write clock while master reset is held
  always_ff @(posedge wclk_i) begin
    if (!mrst_ni) mode_q <= fifo_mode_e'(mode_sel_i);
  end

  assign full     = (wgray_q == {~rgray_sync_i[AW:AW-1], rgray_sync_i[AW-2:0]});
  assign we_o     = wen_i && !full;
  assign wbin_nxt = wbin_q + (AW+1)'(1);

  always_ff @(posedge wclk_i or negedge arst_ni) begin
    if (!arst_ni) begin
      wbin_q  <= '0;
      wgray_q <= '0;
    end else if (we_o) begin
      wbin_q  <= wbin_nxt;
      wgray_q <= wbin_nxt ^ (wbin_nxt >> 1);
    end
  end

  assign waddr_o = wbin_q[AW-1:0];
  assign wgray_o = wgray_q;
  assign wflag_o = (mode_q == MODE_FWFT) ? full : !full;

  p_no_overflow_r3: assert property (@(posedge wclk_i) disable iff (!arst_ni)
    (wen_i && wflag_o == (mode_q == MODE_FWFT)) |=> $stable(wbin_q));
  p_gray_step_r8: assert property (@(posedge wclk_i) disable iff (!arst_ni)
    $onehot0(wgray_q ^ $past(wgray_q)));
  p_mode_hold_r10: assert property (@(posedge wclk_i) disable iff (!mrst_ni)
    mrst_ni |=> $stable(mode_q));
endmodule

// File: rtl/dmf_rd_ctrl.sv
module dmf_rd_ctrl
  import dmf_pkg::*;
#(
  parameter int WIDTH = 18,
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             rclk_i,
  input  logic             mrst_ni,
  input  logic             arst_ni,
  input  logic             mode_sel_i,
  input  logic             ren_i,
  input  logic [AW:0]      wgray_sync_i,
  input  logic [WIDTH-1:0] ram_rdata_i,
  output logic [AW-1:0]    raddr_o,
  output logic [AW:0]      rgray_o,
  output logic [WIDTH-1:0] rdata_o,
  output logic             rflag_o
);
  fifo_mode_e       mode_q;
  logic [AW:0]      rbin_q, rgray_q, rbin_nxt;
  logic [WIDTH-1:0] dout_q;
  logic             ov_q, mem_empty, fwft, load;

  always_ff @(posedge rclk_i) begin
    if (!mrst_ni) mode_q <= fifo_mode_e'(mode_sel_i);
  end

  assign fwft      = (mode_q == MODE_FWFT);
  assign mem_empty = (rgray_q == wgray_sync_i);
  // fall-through refills the output stage whenever it is free or being consumed
  assign load      = fwft ? (!mem_empty && (!ov_q || ren_i)) : (ren_i && !mem_empty);
  assign rbin_nxt  = rbin_q + (AW+1)'(1);

  always_ff @(posedge rclk_i or negedge arst_ni) begin
    if (!arst_ni) begin
      rbin_q  <= '0;
      rgray_q <= '0;
      dout_q  <= '0;
      ov_q    <= 1'b0;
    end else if (load) begin
      rbin_q  <= rbin_nxt;
      rgray_q <= rbin_nxt ^ (rbin_nxt >> 1);
      dout_q  <= ram_rdata_i;
      ov_q    <= 1'b1;
    end else if (fwft && ren_i) begin
      ov_q    <= 1'b0;
    end
  end

  assign raddr_o = rbin_q[AW-1:0];
  assign rgray_o = rgray_q;
  assign rdata_o = dout_q;
  assign rflag_o = fwft ? !ov_q : !mem_empty;

  p_no_underflow_r4: assert property (@(posedge rclk_i) disable iff (!arst_ni)
    (!fwft && ren_i && mem_empty) |=> ($stable(rdata_o) && $stable(rbin_q)));
  p_hold_r5: assert property (@(posedge rclk_i) disable iff (!arst_ni)
    (!fwft && !ren_i) |=> $stable(rdata_o));
  p_or_hold_r7: assert property (@(posedge rclk_i) disable iff (!arst_ni)
    (fwft && !rflag_o && !ren_i) |=> (!rflag_o && $stable(rdata_o)));
  p_gray_step_r8: assert property (@(posedge rclk_i) disable iff (!arst_ni)
    $onehot0(rgray_q ^ $past(rgray_q)));
  p_mode_hold_r10: assert property (@(posedge rclk_i) disable iff (!mrst_ni)
    mrst_ni |=> $stable(mode_q));
endmodule

// File: rtl/dual_mode_fifo.sv
module dual_mode_fifo #(
  parameter int WIDTH = 18,
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             wclk_i,
  input  logic             rclk_i,
  input  logic             rst_ni,
  input  logic             prst_ni,
  input  logic             fwft_i,
  input  logic             wen_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             ren_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic             wflag_o,
  output logic             rflag_o
);
  logic             arst_n, we;
  logic [AW-1:0]    waddr, raddr;
  logic [AW:0]      wgray, rgray, wgray_rs, rgray_ws;
  logic [WIDTH-1:0] ram_rdata;

  assign arst_n = rst_ni & prst_ni;

  dmf_ram #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_ram (
    .wclk_i(wclk_i), .we_i(we), .waddr_i(waddr), .wdata_i(wdata_i),
    .raddr_i(raddr), .rdata_o(ram_rdata)
  );

  dmf_wr_ctrl #(.DEPTH(DEPTH)) u_wr (
    .wclk_i(wclk_i), .mrst_ni(rst_ni), .arst_ni(arst_n), .mode_sel_i(fwft_i),
    .wen_i(wen_i), .rgray_sync_i(rgray_ws), .we_o(we), .waddr_o(waddr),
    .wgray_o(wgray), .wflag_o(wflag_o)
  );

  dmf_rd_ctrl #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_rd (
    .rclk_i(rclk_i), .mrst_ni(rst_ni), .arst_ni(arst_n), .mode_sel_i(fwft_i),
    .ren_i(ren_i), .wgray_sync_i(wgray_rs), .ram_rdata_i(ram_rdata),
    .raddr_o(raddr), .rgray_o(rgray), .rdata_o(rdata_o), .rflag_o(rflag_o)
  );

  dmf_sync #(.W(AW+1)) u_sync_w2r (
    .clk_i(rclk_i), .rst_ni(arst_n), .d_i(wgray), .q_o(wgray_rs)
  );

  dmf_sync #(.W(AW+1)) u_sync_r2w (
    .clk_i(wclk_i), .rst_ni(arst_n), .d_i(rgray), .q_o(rgray_ws)
  );
endmodule

// File: tb/dual_mode_fifo_tb.sv
module dual_mode_fifo_tb;
  localparam int W = 16;
  localparam int D = 8;
  localparam logic [W-1:0] VEC [6] = '{16'h1111, 16'hA5A5, 16'h0000, 16'hFFFF, 16'h3C3C, 16'h0042};

  logic wclk = 1'b0, rclk = 1'b0, rclk_run = 1'b1;
  logic rst_ni = 1'b0, prst_ni = 1'b1, fwft = 1'b0;
  logic wen = 1'b0, ren = 1'b0;
  logic [W-1:0] wdata = '0;
  logic [W-1:0] rdata;
  logic wflag, rflag;
  int checks = 0, failures = 0;

  dual_mode_fifo #(.WIDTH(W), .DEPTH(D)) u_dut (
    .wclk_i(wclk), .rclk_i(rclk), .rst_ni(rst_ni), .prst_ni(prst_ni), .fwft_i(fwft),
    .wen_i(wen), .wdata_i(wdata), .ren_i(ren), .rdata_o(rdata),
    .wflag_o(wflag), .rflag_o(rflag)
  );

  initial forever #4 wclk = ~wclk;  // 125 MHz
  initial begin
    #3;
    forever begin
      #4;
      if (rclk_run) rclk = ~rclk;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic mode);
    rst_ni = 1'b0; prst_ni = 1'b1; wen = 1'b0; ren = 1'b0; fwft = mode;
    repeat (4) @(negedge wclk);
    rst_ni = 1'b1;
    repeat (3) @(negedge wclk);
  endtask

  task automatic push(input logic [W-1:0] d);
    @(negedge wclk); wen = 1'b1; wdata = d;
    @(negedge wclk); wen = 1'b0;
  endtask

  task automatic pop();
    @(negedge rclk); ren = 1'b1;
    @(negedge rclk); ren = 1'b0;
  endtask

  task automatic settle();
    repeat (6) @(negedge rclk);
    repeat (2) @(negedge wclk);
  endtask

  initial begin
    #2_000_000;
    checks++; failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // ---------------- standard mode ----------------
    do_reset(1'b0);
    chk("R11 std wflag", wflag, 1);
    chk("R11 std rflag", rflag, 0);
    chk("R11 std rdata", rdata, 0);

    // R5: table of words, each read explicitly
    for (int i = 0; i < 6; i++) push(VEC[i]);
    settle();
    chk("R5 no read no data", rdata, 0);
    for (int i = 0; i < 6; i++) begin
      chk("R5 not empty", rflag, 1);
      pop();
      chk("R5 data order", rdata, VEC[i]);
    end
    chk("R5 empty after drain", rflag, 0);
    repeat (4) @(negedge rclk);
    chk("R5 hold without ren", rdata, VEC[5]);

    // R4: read while empty
    pop();
    chk("R4 rdata kept", rdata, VEC[5]);
    chk("R4 still empty", rflag, 0);
    push(16'h1234);
    settle();
    pop();
    chk("R4 next word", rdata, 16'h1234);

    // R8: empty released on second read edge after write
    @(negedge wclk); wen = 1'b1; wdata = 16'h5678;
    @(posedge wclk); #1 wen = 1'b0;
    @(posedge rclk); #1 chk("R8 empty after 1 edge", rflag, 0);
    @(posedge rclk); #1 chk("R8 released after 2 edges", rflag, 1);
    pop();
    chk("R8 data", rdata, 16'h5678);

    // R1 / R3: fill, overflow attempt
    do_reset(1'b0);
    for (int i = 0; i < D; i++) begin
      if (i == D - 1) chk("R1 not full before last", wflag, 1);
      push(16'h0100 + 16'(i));
    end
    chk("R1 full after D writes", wflag, 0);
    push(16'hDEAD);
    settle();
    chk("R3 still full", wflag, 0);
    // R8: full released on second write edge after a read
    @(negedge rclk); ren = 1'b1;
    @(posedge rclk); #1 ren = 1'b0;
    @(posedge wclk); #1 chk("R8 full after 1 edge", wflag, 0);
    @(posedge wclk); #1 chk("R8 full released after 2 edges", wflag, 1);
    chk("R3 first word", rdata, 16'h0100);
    for (int i = 1; i < D; i++) begin
      pop();
      chk("R3 order", rdata, 16'h0100 + 16'(i));
    end
    settle();
    chk("R3 overflow word dropped", rflag, 0);

    // R9: stopped read clock
    @(negedge rclk); rclk_run = 1'b0;
    push(16'h0999);
    repeat (10) @(negedge wclk);
    chk("R9 flag frozen", rflag, 0);
    rclk_run = 1'b1;
    @(posedge rclk); #1 chk("R9 one edge", rflag, 0);
    @(posedge rclk); #1 chk("R9 updated", rflag, 1);
    pop();
    chk("R9 data", rdata, 16'h0999);

    // ---------------- fall-through mode ----------------
    do_reset(1'b1);
    chk("R11 fwft wflag", wflag, 0);
    chk("R11 fwft rflag", rflag, 1);
    chk("R11 fwft rdata", rdata, 0);

    // R6: third read edge
    @(negedge wclk); wen = 1'b1; wdata = 16'h0A5A;
    @(posedge wclk); #1 wen = 1'b0;
    for (int e = 1; e <= 3; e++) begin
      @(posedge rclk); #1;
      if (e < 3) chk("R6 not yet", rflag, 1);
      else begin
        chk("R6 ready on 3rd edge", rflag, 0);
        chk("R6 data fell through", rdata, 16'h0A5A);
      end
    end

    // R7: last word held until a real read
    repeat (5) @(negedge rclk);
    chk("R7 stays ready", rflag, 0);
    pop();
    chk("R7 not ready after read", rflag, 1);
    chk("R7 data kept", rdata, 16'h0A5A);
    pop();
    chk("R4 fwft empty read", rflag, 1);
    chk("R4 fwft data kept", rdata, 16'h0A5A);

    // R2 / R3: capacity D+1
    push(16'h0200);
    settle();
    chk("R2 first in output", rdata, 16'h0200);
    for (int i = 1; i <= D; i++) begin
      if (i == D) chk("R2 ready before last", wflag, 0);
      push(16'h0200 + 16'(i));
    end
    chk("R2 full after D+1", wflag, 1);
    push(16'hBEEF);
    settle();
    for (int i = 0; i <= D; i++) begin
      chk("R3 fwft order", rdata, 16'h0200 + 16'(i));
      pop();
    end
    settle();
    chk("R3 fwft overflow dropped", rflag, 1);
    chk("R3 fwft last kept", rdata, 16'h0200 + 16'(D));

    // R10: partial reset keeps mode
    @(negedge wclk); fwft = 1'b0; prst_ni = 1'b0;
    repeat (3) @(negedge wclk);
    prst_ni = 1'b1;
    repeat (2) @(negedge wclk);
    chk("R10 prst wflag", wflag, 0);
    chk("R10 prst rflag", rflag, 1);
    chk("R10 prst rdata", rdata, 0);
    push(16'h0777);
    settle();
    chk("R10 still fall-through", rflag, 0);
    chk("R10 data without read", rdata, 16'h0777);
    do_reset(1'b0);
    chk("R10 master sets std wflag", wflag, 1);
    chk("R10 master sets std rflag", rflag, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule